// File: doc/BRIEF.md
# Segmented DAC code decoder

This block turns a 12-bit converter code into the switch controls of a segmented current-steering converter. The two most significant code bits select how many of three equal segment switches are closed. Each segment switch steers one quarter of the full reference current. The ten low bits go straight to the binary ladder switches, which share the remaining quarter.

Beside the switch controls, the block reports the ideal output that the analog stage should reach. The value is signed fixed-point, in units of the reference input, and it covers two transfer modes:

- **Unipolar:** the output is the negative code fraction times the reference.
- **Bipolar:** the code is read as offset binary, with mid-code giving zero and one step equal to the reference divided by 2048.

Every output comes from a register, with one clock of latency, and is cleared by reset.

Top module: `dac_seg_decoder`

## Requirements
- R1: `seg_o` is a thermometer code of the two code MSBs: 00 sets no bit, 01 sets bit 0, 10 sets bits 1:0, and 11 sets bits 2:0.
- R2: `ladder_o` equals code bits 9:0, bit for bit.
- R3: With `bipolar_i` = 0, `ideal_o` equals floor(-code × ref / 4096). Code 0x800 gives floor(-ref/2), and code 0 gives 0.
- R4: With `bipolar_i` = 1, `ideal_o` equals floor((code - 2048) × ref / 2048). Code 0x800 gives 0, code 0x000 gives -ref, and code 0xFFF gives floor(2047 × ref / 2048).
- R5: `ideal_o` is 17 bits wide and never wraps, even at the extreme reference values -32768 and +32767.
- R6: Each output reflects the inputs sampled at the previous rising clock edge. A change of input between edges leaves the outputs unchanged.
- R7: While `rst_n` is low, all outputs are zero.
- R8: The number of closed segment switches times 1024, plus the ladder value, equals the registered code. This is the current-weight balance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_i | input | 12 | Converter code |
| bipolar_i | input | 1 | Transfer mode: 0 = unipolar, 1 = bipolar (offset binary) |
| ref_i | input | 16 | Signed reference value |
| seg_o | output | 3 | Thermometer segment switch controls |
| ladder_o | output | 10 | Binary ladder switch controls |
| ideal_o | output | 17 | Signed ideal output value |

## Verification
The only state is one output register stage, so a wrong stored value appears at the ports on the very next cycle. A wrong segment decode breaks the thermometer shape or the current-weight balance. A wrong mode or shift selection puts `ideal_o` off by a factor of two or by a sign. A stale or early register shows up as a one-cycle mismatch against the reference model. Extreme references and the three anchor codes expose truncation and width errors that random codes seldom reach.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
    localparam int DEF_CODE_W = 12;
    localparam int DEF_SEG_BITS = 2;
    localparam int DEF_REF_W = 16;

    typedef enum logic {
        MODE_UNIPOLAR = 1'b0,
        MODE_BIPOLAR  = 1'b1
    } dac_mode_e;
endpackage

// File: rtl/dac_seg_thermo.sv
module dac_seg_thermo #(
    parameter int SEG_BITS = 2,
    localparam int SEG_N = (1 << SEG_BITS) - 1
) (
    input  logic [SEG_BITS-1:0] msb_i,
    output logic [SEG_N-1:0]    seg_o
);
    for (genvar gi = 0; gi < SEG_N; gi++) begin : g_seg
        // segment gi closes once the MSB count exceeds its index
        assign seg_o[gi] = (msb_i > SEG_BITS'(gi));
    end
endmodule

// File: rtl/dac_seg_ideal.sv
module dac_seg_ideal
    import dac_seg_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int REF_W = 16,
    localparam int OUT_W = REF_W + 1,
    localparam int PROD_W = REF_W + CODE_W + 1
) (
    input  logic [CODE_W-1:0]       code_i,
    input  dac_mode_e               mode_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic signed [OUT_W-1:0] ideal_o
);
    localparam logic signed [CODE_W:0] MID_CODE = (CODE_W + 1)'(1 << (CODE_W - 1));

    logic signed [CODE_W:0]   code_s;
    logic signed [CODE_W:0]   factor;
    logic signed [PROD_W-1:0] factor_x;
    logic signed [PROD_W-1:0] ref_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        code_s = {1'b0, code_i};
        // bipolar: offset from mid-code; unipolar: negated code
        factor = (mode_i == MODE_BIPOLAR) ? (code_s - MID_CODE) : -code_s;
        factor_x = PROD_W'(factor);
        ref_x = PROD_W'(ref_i);
        prod = factor_x * ref_x;
        // arithmetic shift floors toward negative infinity
        scaled = (mode_i == MODE_BIPOLAR) ? (prod >>> (CODE_W - 1)) : (prod >>> CODE_W);
        ideal_o = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
    import dac_seg_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int SEG_BITS = DEF_SEG_BITS,
    parameter int REF_W = DEF_REF_W,
    localparam int SEG_N = (1 << SEG_BITS) - 1,
    localparam int LAD_W = CODE_W - SEG_BITS,
    localparam int OUT_W = REF_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    bipolar_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [SEG_N-1:0]        seg_o,
    output logic [LAD_W-1:0]        ladder_o,
    output logic signed [OUT_W-1:0] ideal_o
);
    typedef struct packed {
        logic [SEG_N-1:0]        seg;
        logic [LAD_W-1:0]        ladder;
        logic signed [OUT_W-1:0] ideal;
    } dec_state_t;

    dec_state_t state_d;
    dec_state_t state_q;

    logic [SEG_N-1:0]        seg_w;
    logic signed [OUT_W-1:0] ideal_w;
    dac_mode_e               mode_w;

    assign mode_w = bipolar_i ? MODE_BIPOLAR : MODE_UNIPOLAR;

    dac_seg_thermo #(
        .SEG_BITS(SEG_BITS)
    ) u_thermo (
        .msb_i(code_i[CODE_W-1 -: SEG_BITS]),
        .seg_o(seg_w)
    );

    dac_seg_ideal #(
        .CODE_W(CODE_W),
        .REF_W (REF_W)
    ) u_ideal (
        .code_i (code_i),
        .mode_i (mode_w),
        .ref_i  (ref_i),
        .ideal_o(ideal_w)
    );

    always_comb begin
        state_d = state_q;
        state_d.seg = seg_w;
        state_d.ladder = code_i[LAD_W-1:0];
        state_d.ideal = ideal_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_o = state_q.seg;
    assign ladder_o = state_q.ladder;
    assign ideal_o = state_q.ideal;
endmodule

// File: rtl/dac_seg_decoder_chk.sv
module dac_seg_decoder_chk #(
    parameter int CODE_W = 12,
    parameter int SEG_BITS = 2,
    parameter int REF_W = 16,
    localparam int SEG_N = (1 << SEG_BITS) - 1,
    localparam int LAD_W = CODE_W - SEG_BITS,
    localparam int OUT_W = REF_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CODE_W-1:0]       code_i,
    input logic                    bipolar_i,
    input logic [SEG_N-1:0]        seg_o,
    input logic [LAD_W-1:0]        ladder_o,
    input logic signed [OUT_W-1:0] ideal_o
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    logic [CODE_W:0] weight;
    assign weight = ((CODE_W + 1)'($countones(seg_o)) << LAD_W) + (CODE_W + 1)'(ladder_o);

    assert_seg_thermo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_o & (seg_o + 1'b1)) == '0));

    assert_ladder_pass_R2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ladder_o == $past(code_i[LAD_W-1:0])));

    assert_bipolar_mid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bipolar_i && code_i == MID) |=> (ideal_o == '0));

    assert_unipolar_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bipolar_i && code_i == '0) |=> (ideal_o == '0));

    assert_weight_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (weight == (CODE_W + 1)'($past(code_i))));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R7: assert (seg_o == '0 && ladder_o == '0 && ideal_o == '0);
        end
    end
endmodule

bind dac_seg_decoder dac_seg_decoder_chk #(
    .CODE_W  (CODE_W),
    .SEG_BITS(SEG_BITS),
    .REF_W   (REF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_i   (code_i),
    .bipolar_i(bipolar_i),
    .seg_o    (seg_o),
    .ladder_o (ladder_o),
    .ideal_o  (ideal_o)
);

// File: tb/dac_seg_decoder_bench.sv
`timescale 1ns/1ps
module dac_seg_decoder_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        code_i = '0;
    logic               bipolar_i = 1'b0;
    logic signed [15:0] ref_i = '0;
    logic [2:0]         seg_o;
    logic [9:0]         ladder_o;
    logic signed [16:0] ideal_o;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    logic [2:0]  prev_seg = '0;
    logic [9:0]  prev_lad = '0;
    longint      prev_ideal = 0;

    always #4 clk = ~clk;

    dac_seg_decoder u_dac_seg_decoder (
        .clk(clk), .rst_n(rst_n), .code_i(code_i), .bipolar_i(bipolar_i),
        .ref_i(ref_i), .seg_o(seg_o), .ladder_o(ladder_o), .ideal_o(ideal_o)
    );

    function automatic longint exp_ideal(input logic [11:0] c, input logic b, input logic signed [15:0] r);
        longint p;
        if (b) begin
            p = (longint'(c) - 2048) * longint'(r);
            return p >>> 11;
        end
        p = -longint'(c) * longint'(r);
        return p >>> 12;
    endfunction

    function automatic logic [2:0] exp_seg(input logic [1:0] m);
        return 3'((4'd1 << m) - 4'd1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] c, input logic b, input logic signed [15:0] r, input string req);
        longint ei;
        code_i = c; bipolar_i = b; ref_i = r;
        #1;
        // R6: outputs hold the previous sample until the next edge
        check(seg_o == prev_seg && ladder_o == prev_lad && longint'(ideal_o) == prev_ideal,
              "R6 hold", longint'(ideal_o), prev_ideal);
        @(posedge clk);
        @(negedge clk);
        ei = exp_ideal(c, b, r);
        check(seg_o == exp_seg(c[11:10]), "R1 seg", seg_o, exp_seg(c[11:10]));
        check(ladder_o == c[9:0], "R2 ladder", ladder_o, c[9:0]);
        check(longint'(ideal_o) == ei, req, longint'(ideal_o), ei);
        check(longint'($countones(seg_o)) * 1024 + longint'(ladder_o) == longint'(c),
              "R8 weight", longint'($countones(seg_o)) * 1024 + longint'(ladder_o), c);
        prev_seg = seg_o; prev_lad = ladder_o; prev_ideal = longint'(ideal_o);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        code_i = 12'hABC; bipolar_i = 1'b1; ref_i = 16'sd1000;
        repeat (3) @(negedge clk);
        // R7: reset holds outputs at zero despite live inputs
        check(seg_o == 0 && ladder_o == 0 && ideal_o == 0, "R7 reset", ideal_o, 0);
        rst_n = 1'b1;
        code_i = '0; bipolar_i = 1'b0; ref_i = '0;
        @(negedge clk);
        prev_seg = seg_o; prev_lad = ladder_o; prev_ideal = longint'(ideal_o);

        // directed anchors, R3 unipolar
        apply(12'h000, 1'b0, 16'sd10000, "R3 uni zero");
        apply(12'h800, 1'b0, 16'sd10000, "R3 uni half");
        apply(12'h800, 1'b0, 16'sd10001, "R3 uni half odd floor");
        apply(12'hFFF, 1'b0, 16'sd4096, "R3 uni full");
        apply(12'h001, 1'b0, 16'sd1, "R3 uni floor");
        // R4 bipolar anchors
        apply(12'h800, 1'b1, 16'sd12345, "R4 bip mid");
        apply(12'h000, 1'b1, 16'sd12345, "R4 bip min");
        apply(12'hFFF, 1'b1, 16'sd2048, "R4 bip max");
        apply(12'h7FF, 1'b1, 16'sd3, "R4 bip floor");
        // R5 extremes
        apply(12'h000, 1'b1, -16'sd32768, "R5 bip +32768");
        apply(12'hFFF, 1'b0, -16'sd32768, "R5 uni neg ref");
        apply(12'hFFF, 1'b1, 16'sd32767, "R5 bip pos ref");
        apply(12'h000, 1'b1, 16'sd32767, "R5 bip min pos ref");
        // R1 segment boundaries
        apply(12'h3FF, 1'b0, 16'sd100, "R3 seg edge 3FF");
        apply(12'h400, 1'b0, 16'sd100, "R3 seg edge 400");
        apply(12'hC00, 1'b1, 16'sd100, "R4 seg edge C00");

        for (int i = 0; i < 400; i++) begin
            logic [11:0] rc;
            logic rb;
            logic signed [15:0] rr;
            rc = 12'($urandom);
            rb = 1'($urandom);
            rr = 16'($urandom);
            apply(rc, rb, rr, rb ? "R4 random" : "R3 random");
        end

        // R7: mid-run reset clears outputs
        code_i = 12'hFFF; bipolar_i = 1'b1; ref_i = 16'sd500;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(seg_o == 0 && ladder_o == 0 && ideal_o == 0, "R7 mid reset", ideal_o, 0);
        @(negedge clk);
        check(seg_o == 0 && ladder_o == 0 && ideal_o == 0, "R7 held reset", ideal_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule